// File: doc/BRIEF.md
# Banked Configuration Register Space Behind an Index/Data Port Pair

This block is a legacy-style configuration space that a host reaches through two byte-wide I/O ports. It writes a register number to the index port. It then reads or writes that register through the data port, at the next address up. Accesses arrive as single-cycle read and write strobes with an 8-bit I/O address. Reads come back one clock later with a valid flag. The block stores a logical device number. Register numbers 0x30 and above are decoded into the bank of the device that number selects. Register numbers below 0x30 are global, so they stay visible whichever bank is selected. For each device the block drives an enable bit, a 16-bit I/O base address, a serial IRQ number and an IRQ type. It also holds two boot-flag bytes: a version byte and a console-selection byte.

The space is guarded by a small state machine with three states. `LK_LOCKED` is the reset state, and in it the data port is dead. A write of 0xA5 to the index port takes it from `LK_LOCKED` to `LK_ARMED` (transition *arm*). A second consecutive 0xA5 takes it from `LK_ARMED` to `LK_OPEN` (transition *open*). Any other index value written in `LK_ARMED` returns it to `LK_LOCKED` (transition *restart*). In `LK_OPEN`, a write of 0xAA to the index port returns it to `LK_LOCKED` (transition *close*). Any other index write in `LK_OPEN` loads the index register and leaves the state unchanged (transition *select*).

Top module: `sio_cfg_space`

## Requirements
- R1: After reset the space is locked and every device enable is 0. Each device's base address, IRQ number and IRQ type hold their parameter defaults (0x03F8, 4, 0x01). The version byte is 0x01 and the console byte is 0x40. The index register and the device number are 0.
- R2: While locked, a data-port write changes nothing. A data-port read returns 0xFF, and so does an index-port read.
- R3: Two consecutive writes of 0xA5 to the index port unlock the space. If any other value is written to the index port between them, the sequence restarts and two further 0xA5 writes are needed. The unlocking writes do not load the index register.
- R4: While unlocked, writing 0xAA to the index port locks the space again, and the index register keeps its value.
- R5: A read strobe to the index port (parameter, default 0x2E) or to the data port (index port + 1) produces `rd_valid` with the data for exactly one cycle, one clock after the strobe. A read to any other address produces no `rd_valid`. While unlocked, an index-port read returns the index register.
- R6: Global register 0x07 holds the selected device number. Writes to registers 0x30 and above reach only the selected device's bank, and reads of those registers come from that bank. Each device's outputs sit at slice position device×width in their bus.
- R7: Register 0x30 bit 0 is the device enable, driven on `dev_en[device]`. Reads of 0x30 return the enable in bit 0 with the other bits 0.
- R8: Register 0x60 holds the upper byte and register 0x61 the lower byte of the device's 16-bit I/O base address.
- R9: Register 0x70 holds a 4-bit serial IRQ number in bits 3:0, and reads return it with the upper bits 0. Register 0x71 holds the 8-bit IRQ type.
- R10: Global register 0x28 (version) and global register 0x2D (console) can be read and written in every bank. `console_sel` is bits 7:6 of register 0x2D, encoded 01 physical UART, 10 virtual UART, 11 reserved.
- R11: When the device number is not below NUM_LDN (default 16), device-space reads return 0xFF and device-space writes are ignored. Reads of unimplemented global registers return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after io_rd to a decoded port |
| dev_en | output | NUM_LDN | Per-device enable |
| dev_base | output | NUM_LDN*16 | Per-device I/O base address |
| dev_irq_num | output | NUM_LDN*4 | Per-device serial IRQ number |
| dev_irq_type | output | NUM_LDN*8 | Per-device IRQ type |
| boot_ver | output | 8 | Boot-flags version byte |
| console_sel | output | 2 | Console selection, bits 7:6 of register 0x2D |

## Verification
The assertions assume the host raises at most one of `io_wr` and `io_rd` in any cycle. They also assume each access is a single-cycle pulse, so every rule about the cycle after a strobe has only one cause. The bench drives each access from a task that raises one strobe at a falling edge and drops it at the next falling edge, which keeps it within both assumptions. Expected read bytes are queued before each strobe. A monitor takes them off the queue at the falling edge on which `rd_valid` is high, so any read the design returns without one being expected is reported as a failure.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    localparam logic [7:0] KEY_OPEN        = 8'hA5;
    localparam logic [7:0] KEY_CLOSE       = 8'hAA;

    localparam logic [7:0] REG_LDN         = 8'h07;
    localparam logic [7:0] REG_BOOTVER     = 8'h28;
    localparam logic [7:0] REG_CONSOLE     = 8'h2D;
    localparam logic [7:0] DEV_SPACE_START = 8'h30;
    localparam logic [7:0] REG_ENABLE      = 8'h30;
    localparam logic [7:0] REG_BASE_HI     = 8'h60;
    localparam logic [7:0] REG_BASE_LO     = 8'h61;
    localparam logic [7:0] REG_IRQ_NUM     = 8'h70;
    localparam logic [7:0] REG_IRQ_TYPE    = 8'h71;

    localparam logic [7:0] DEAD_BYTE       = 8'hFF;

endpackage

// File: rtl/sio_lock_fsm.sv
module sio_lock_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    lock_state_e state_q;
    lock_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // next state: arm, open, restart, close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (idx_wr && wdata == KEY_OPEN) state_d = LK_ARMED;
            LK_ARMED:  if (idx_wr) state_d = (wdata == KEY_OPEN) ? LK_OPEN : LK_LOCKED;
            LK_OPEN:   if (idx_wr && wdata == KEY_CLOSE) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unlocked = (state_q == LK_OPEN);
        idx_load = (state_q == LK_OPEN) && idx_wr && (wdata != KEY_CLOSE);
    end

    // R3
    lk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && idx_wr && wdata != KEY_OPEN) |=> (state_q == LK_LOCKED));

    // R3
    lk_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && idx_wr && wdata == KEY_OPEN) |=> unlocked);

    // R3
    lk_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_LOCKED) |=> !unlocked);

    // R4
    lk_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] DEF_BASE = 16'h03F8,
    parameter logic [3:0]  DEF_IRQ  = 4'd4,
    parameter logic [7:0]  DEF_TYPE = 8'h01
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  wdata,
    output logic        en,
    output logic [15:0] base,
    output logic [3:0]  irq_num,
    output logic [7:0]  irq_type,
    output logic [7:0]  rd_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            base     <= DEF_BASE;
            irq_num  <= DEF_IRQ;
            irq_type <= DEF_TYPE;
        end else if (wr_en) begin
            case (reg_idx)
                REG_ENABLE:   en          <= wdata[0];
                REG_BASE_HI:  base[15:8]  <= wdata;
                REG_BASE_LO:  base[7:0]   <= wdata;
                REG_IRQ_NUM:  irq_num     <= wdata[3:0];
                REG_IRQ_TYPE: irq_type    <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_idx)
            REG_ENABLE:   rd_byte = {7'd0, en};
            REG_BASE_HI:  rd_byte = base[15:8];
            REG_BASE_LO:  rd_byte = base[7:0];
            REG_IRQ_NUM:  rd_byte = {4'd0, irq_num};
            REG_IRQ_TYPE: rd_byte = irq_type;
            default:      rd_byte = 8'h00;
        endcase
    end

    // R7
    bank_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_idx == REG_ENABLE) |=> $stable(en));

    // R8
    bank_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (reg_idx == REG_BASE_HI || reg_idx == REG_BASE_LO)) |=> $stable(base));

    // R9
    bank_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_idx == REG_IRQ_NUM) |=> $stable(irq_num));

endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0]  INDEX_PORT  = 8'h2E,
    parameter int          NUM_LDN     = 16,
    parameter logic [15:0] DEF_BASE    = 16'h03F8,
    parameter logic [3:0]  DEF_IRQ     = 4'd4,
    parameter logic [7:0]  DEF_TYPE    = 8'h01,
    parameter logic [7:0]  DEF_BOOTVER = 8'h01,
    parameter logic [7:0]  DEF_CONSOLE = 8'h40
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_addr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 rd_valid,
    output logic [NUM_LDN-1:0]   dev_en,
    output logic [NUM_LDN*16-1:0] dev_base,
    output logic [NUM_LDN*4-1:0] dev_irq_num,
    output logic [NUM_LDN*8-1:0] dev_irq_type,
    output logic [7:0]           boot_ver,
    output logic [1:0]           console_sel
);

    localparam logic [7:0] DATA_PORT = INDEX_PORT + 8'd1;
    localparam int         LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic       unlocked;
    logic       idx_load;
    logic       idx_port_wr;
    logic       data_wr;
    logic       port_hit_rd;
    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic [7:0] console_q;
    logic       ldn_ok;
    logic       dev_space;
    logic [7:0] bank_sel;
    logic [7:0] data_view;
    logic [7:0] rd_next;
    logic [7:0] bank_rd [NUM_LDN];

    assign idx_port_wr = io_wr && (io_addr == INDEX_PORT);
    assign data_wr     = io_wr && (io_addr == DATA_PORT) && unlocked;
    assign port_hit_rd = io_rd && ((io_addr == INDEX_PORT) || (io_addr == DATA_PORT));
    assign ldn_ok      = (int'(ldn_q) < NUM_LDN);
    assign dev_space   = (index_q >= DEV_SPACE_START);
    assign console_sel = console_q[7:6];

    sio_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_port_wr),
        .wdata    (io_wdata),
        .unlocked (unlocked),
        .idx_load (idx_load)
    );

    // index and global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q   <= 8'h00;
            ldn_q     <= 8'h00;
            boot_ver  <= DEF_BOOTVER;
            console_q <= DEF_CONSOLE;
        end else begin
            if (idx_load) index_q <= io_wdata;
            if (data_wr) begin
                case (index_q)
                    REG_LDN:     ldn_q     <= io_wdata;
                    REG_BOOTVER: boot_ver  <= io_wdata;
                    REG_CONSOLE: console_q <= io_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-device banks
    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        logic bank_wr;
        assign bank_wr = data_wr && dev_space && (ldn_q == 8'(g));

        sio_dev_bank #(
            .DEF_BASE (DEF_BASE),
            .DEF_IRQ  (DEF_IRQ),
            .DEF_TYPE (DEF_TYPE)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .reg_idx  (index_q),
            .wdata    (io_wdata),
            .en       (dev_en[g]),
            .base     (dev_base[g*16 +: 16]),
            .irq_num  (dev_irq_num[g*4 +: 4]),
            .irq_type (dev_irq_type[g*8 +: 8]),
            .rd_byte  (bank_rd[g])
        );
    end

    // read path
    always_comb begin
        bank_sel = ldn_ok ? bank_rd[ldn_q[LDN_W-1:0]] : DEAD_BYTE;
        case (index_q)
            REG_LDN:     data_view = ldn_q;
            REG_BOOTVER: data_view = boot_ver;
            REG_CONSOLE: data_view = console_q;
            default:     data_view = dev_space ? bank_sel : 8'h00;
        endcase
        if (io_addr == INDEX_PORT) rd_next = unlocked ? index_q : DEAD_BYTE;
        else                       rd_next = unlocked ? data_view : DEAD_BYTE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            io_rdata <= 8'h00;
        end else begin
            rd_valid <= port_hit_rd;
            if (port_hit_rd) io_rdata <= rd_next;
        end
    end

    // R2
    locked_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_wr && io_addr == DATA_PORT) |=>
        ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq_num) &&
         $stable(dev_irq_type) && $stable(boot_ver) && $stable(console_sel)));

    // R2
    locked_rd_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd && io_addr == DATA_PORT) |=> (rd_valid && io_rdata == DEAD_BYTE));

    // R5
    stray_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd || (io_addr != INDEX_PORT && io_addr != DATA_PORT)) |=> !rd_valid);

    // R10
    console_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == REG_CONSOLE) |=> (console_sel == $past(io_wdata[7:6])));

endmodule

// File: tb/tb_sio_cfg_space.sv
module tb_sio_cfg_space;

    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [7:0]    io_addr = 8'h00;
    logic [7:0]    io_wdata = 8'h00;
    logic [7:0]    io_rdata;
    logic          rd_valid;
    logic [NL-1:0] dev_en;
    logic [NL*16-1:0] dev_base;
    logic [NL*4-1:0]  dev_irq_num;
    logic [NL*8-1:0]  dev_irq_type;
    logic [7:0]    boot_ver;
    logic [1:0]    console_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    sio_cfg_space dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .rd_valid(rd_valid), .dev_en(dev_en), .dev_base(dev_base),
        .dev_irq_num(dev_irq_num), .dev_irq_type(dev_irq_type),
        .boot_ver(boot_ver), .console_sel(console_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic setreg(input logic [7:0] idx, input logic [7:0] d);
        wr(8'h2E, idx);
        wr(8'h2F, d);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic getreg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        wr(8'h2E, idx);
        rd_exp(8'h2F, exp, tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected read data actual=%0h expected=none", io_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", t, io_rdata, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dev_en", dev_en, 0);
        chk("R1 base dev2", dev_base[2*16 +: 16], 16'h03F8);
        chk("R1 irq dev13", dev_irq_num[13*4 +: 4], 4'd4);
        chk("R1 type dev0", dev_irq_type[0 +: 8], 8'h01);
        chk("R1 boot_ver", boot_ver, 8'h01);
        chk("R1 console_sel", console_sel, 2'b01);

        // R2 locked space
        rd_exp(8'h2F, 8'hFF, "R2 locked data read");
        rd_exp(8'h2E, 8'hFF, "R2 locked index read");
        wr(8'h2E, 8'h30);
        wr(8'h2F, 8'h01);
        @(negedge clk);
        chk("R2 locked write ignored", dev_en, 0);

        // R5 stray address
        @(negedge clk);
        io_rd = 1'b1; io_addr = 8'h80;
        @(negedge clk);
        io_rd = 1'b0;
        chk("R5 stray read no valid", rd_valid, 1'b0);

        // R3 restart then unlock
        wr(8'h2E, 8'hA5);
        wr(8'h2E, 8'h11);
        wr(8'h2E, 8'hA5);
        rd_exp(8'h2F, 8'hFF, "R3 restart keeps locked");
        wr(8'h2E, 8'hA5);
        rd_exp(8'h2E, 8'h00, "R3 unlocked, index not loaded");

        // R6/R7 device 2
        setreg(8'h07, 8'h02);
        setreg(8'h30, 8'hFF);
        @(negedge clk);
        chk("R7 dev_en bit2", dev_en, 16'h0004);
        getreg(8'h30, 8'h01, "R7 enable readback");

        // R8
        setreg(8'h60, 8'h12);
        setreg(8'h61, 8'h34);
        @(negedge clk);
        chk("R8 base dev2", dev_base[2*16 +: 16], 16'h1234);
        getreg(8'h60, 8'h12, "R8 base hi readback");

        // R9
        setreg(8'h70, 8'h3B);
        setreg(8'h71, 8'h02);
        @(negedge clk);
        chk("R9 irq num", dev_irq_num[2*4 +: 4], 4'hB);
        chk("R9 irq type", dev_irq_type[2*8 +: 8], 8'h02);
        getreg(8'h70, 8'h0B, "R9 irq readback");

        // R6 switch to device 0x0D
        setreg(8'h07, 8'h0D);
        getreg(8'h30, 8'h00, "R6 dev13 enable clear");
        getreg(8'h60, 8'h03, "R6 dev13 base default");
        setreg(8'h30, 8'h01);
        @(negedge clk);
        chk("R6 dev_en two banks", dev_en, 16'h2004);
        chk("R6 dev2 base kept", dev_base[2*16 +: 16], 16'h1234);

        // R10 globals in any bank
        getreg(8'h07, 8'h0D, "R10 ldn visible");
        getreg(8'h28, 8'h01, "R10 version visible");
        setreg(8'h2D, 8'h80);
        setreg(8'h28, 8'h07);
        @(negedge clk);
        chk("R10 console virtual", console_sel, 2'b10);
        chk("R10 boot_ver", boot_ver, 8'h07);
        getreg(8'h2D, 8'h80, "R10 console readback");

        // R11 out-of-range device, unimplemented global
        setreg(8'h07, 8'h20);
        getreg(8'h30, 8'hFF, "R11 bad ldn read");
        setreg(8'h30, 8'h00);
        @(negedge clk);
        chk("R11 bad ldn write ignored", dev_en, 16'h2004);
        getreg(8'h10, 8'h00, "R11 unimplemented global");

        // R4 relock
        wr(8'h2E, 8'h07);
        wr(8'h2E, 8'hAA);
        rd_exp(8'h2F, 8'hFF, "R4 relocked");
        wr(8'h2F, 8'h02);
        wr(8'h2E, 8'hA5);
        wr(8'h2E, 8'hA5);
        rd_exp(8'h2E, 8'h07, "R4 index kept over lock");
        rd_exp(8'h2F, 8'h20, "R4 locked write ignored");

        repeat (3) @(negedge clk);
        chk("R5 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule